// File: doc/BRIEF.md
# Transaction Ack-Count Tracker

This block keeps the pending-acknowledgement count for one outstanding coherence miss and sorts every response that arrives for that miss into an event. The surrounding cache controller allocates the entry when it issues a request. The controller then presents each response together with four things: the response type, a flag that says the sender is a peer cache of the same level, the signed ack count the message carries, and the controller's current transient state. One cycle later the block returns a registered event code and the updated count. The controller uses the event to pick its next transition, for example to send an unblock after shared data from a peer.

Completion is decided by one test: the stored count minus the count carried in the message must be zero. The stored count is signed. Invalidation acks may reach the entry before the data message that carries the expected total, and they drive the count below zero. Shared data from a peer, received while a shared read is pending, has its own event. That event is chosen before the completion test is made. A response type the block does not know sets an error flag, and the flag stays set until reset.

Top module: `ackt_tracker`

## Requirements
- R1: After a synchronous reset, `pending_cnt` is 0, `evt_valid` is 0 and `err_flag` is 0.
- R2: A cycle with `alloc` high sets `pending_cnt` to 0 on the next edge. A response presented in that same cycle is dropped: no event is raised and the count stays 0.
- R3: Response type 1 (exclusive data) always yields event 1, whatever the count or state, and leaves the count unchanged.
- R4: Response type 0 (data) with `rsp_from_peer` high and `txn_state` equal to 1 (shared-read pending) or 2 (shared-read pending, invalidated) yields event 2. This takes precedence over the completion test, and the count is unchanged. In any other state, peer data is classified by R5.
- R5: Any other data response yields event 3 (data, complete) when `pending_cnt - rsp_ack_cnt == 0`, and event 4 (data, more to come) when it is not.
- R6: Response type 2 (ack) yields event 5 (last ack) when `pending_cnt - rsp_ack_cnt == 0`, and event 6 (partial ack) when it is not.
- R7: Every response classified under R5 or R6 sets the count to `pending_cnt - rsp_ack_cnt`, computed as a signed value. The count may go negative. It is exactly 0 whenever event 3 or event 5 is reported.
- R8: Response type 3 (writeback ack) yields event 7 and leaves the count unchanged.
- R9: Response types 4 to 7 raise no event and leave the count unchanged. They set `err_flag`, and the flag stays set through later responses and allocations until reset.
- R10: The event and the new count appear on the outputs on the first clock edge after the response is sampled. In a cycle with no response, `evt_valid` is 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc | input | 1 | Allocates the entry and clears the count |
| rsp_valid | input | 1 | A response is presented this cycle |
| rsp_type | input | 3 | 0 data, 1 exclusive data, 2 ack, 3 writeback ack, 4-7 illegal |
| rsp_from_peer | input | 1 | The sender is a peer cache of the same level |
| rsp_ack_cnt | input | ACK_W | Signed ack count carried by the message |
| txn_state | input | 3 | Transient state: 0 other, 1 shared-read pending, 2 shared-read pending and invalidated, 3 write pending, 4 upgrade pending, 5 replacement pending |
| evt_valid | output | 1 | An event is reported this cycle |
| evt_code | output | 3 | Event code 1 to 7, as defined in R3 to R8 |
| pending_cnt | output | CNT_W | Signed pending-ack count |
| err_flag | output | 1 | Sticky illegal-response flag |

## Verification
If the count held the wrong value, the next data or ack response would show it one cycle later: the event would switch between the complete and partial codes, and `pending_cnt` would differ from the value the bench computes. The ordering cases therefore matter most. These are acks arriving ahead of the data that carries the total, which pushes the count negative, and data arriving first. A wrong priority in the classifier shows as the wrong event code on the very next edge. The clearest case is peer shared data arriving when the count difference also happens to be zero. A lost or self-clearing error flag is caught by reading `err_flag` after later responses and after an allocation.

// File: rtl/ackt_pkg.sv
package ackt_pkg;
  // response type encodings (decoded by the classifier)
  localparam logic [2:0] RSP_DATA   = 3'd0;
  localparam logic [2:0] RSP_XDATA  = 3'd1;
  localparam logic [2:0] RSP_ACK    = 3'd2;
  localparam logic [2:0] RSP_WBACK  = 3'd3;

  // transient state encodings relevant to classification
  localparam logic [2:0] ST_RD_WAIT     = 3'd1;
  localparam logic [2:0] ST_RD_WAIT_INV = 3'd2;

  // event encodings
  localparam logic [2:0] EV_NONE      = 3'd0;
  localparam logic [2:0] EV_XDATA     = 3'd1;
  localparam logic [2:0] EV_PEER_SH   = 3'd2;
  localparam logic [2:0] EV_DATA_LAST = 3'd3;
  localparam logic [2:0] EV_DATA_PART = 3'd4;
  localparam logic [2:0] EV_ACK_LAST  = 3'd5;
  localparam logic [2:0] EV_ACK_PART  = 3'd6;
  localparam logic [2:0] EV_WB_DONE   = 3'd7;
endpackage

// File: rtl/ackt_classify.sv
module ackt_classify
  import ackt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int ACK_W = 6
) (
  input  logic                    in_valid,
  input  logic [2:0]              in_type,
  input  logic                    in_peer,
  input  logic signed [ACK_W-1:0] in_ack,
  input  logic [2:0]              in_state,
  input  logic signed [CNT_W-1:0] cur_cnt,
  output logic                    fire,
  output logic [2:0]              code,
  output logic                    upd_en,
  output logic signed [CNT_W-1:0] upd_cnt,
  output logic                    bad_type
);
  localparam int EXT_W = CNT_W - ACK_W;

  logic signed [CNT_W-1:0] ack_ext;
  logic                    done;
  logic                    rd_wait;

  assign ack_ext = {{EXT_W{in_ack[ACK_W-1]}}, in_ack};
  assign upd_cnt = cur_cnt - ack_ext;
  assign done    = (upd_cnt == '0);
  assign rd_wait = (in_state == ST_RD_WAIT) || (in_state == ST_RD_WAIT_INV);

  always_comb begin
    fire     = 1'b0;
    code     = EV_NONE;
    upd_en   = 1'b0;
    bad_type = 1'b0;
    if (in_valid) begin
      unique case (in_type)
        RSP_XDATA: begin
          fire = 1'b1;
          code = EV_XDATA;
        end
        RSP_DATA: begin
          fire = 1'b1;
          if (in_peer && rd_wait) begin
            code = EV_PEER_SH;
          end else begin
            upd_en = 1'b1;
            code   = done ? EV_DATA_LAST : EV_DATA_PART;
          end
        end
        RSP_ACK: begin
          fire   = 1'b1;
          upd_en = 1'b1;
          code   = done ? EV_ACK_LAST : EV_ACK_PART;
        end
        RSP_WBACK: begin
          fire = 1'b1;
          code = EV_WB_DONE;
        end
        default: bad_type = 1'b1;
      endcase
    end
  end

  // exclusive data never touches the count
  always_comb begin
    if (in_valid && in_type == RSP_XDATA)
      a_xdata_no_upd_r3: assert (!upd_en);
  end
endmodule

// File: rtl/ackt_count_reg.sv
module ackt_count_reg #(
  parameter int CNT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    upd_en,
  input  logic signed [CNT_W-1:0] upd_cnt,
  output logic signed [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (upd_en) cnt <= upd_cnt;
  end

  p_alloc_clears_r2: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!clr && !upd_en) |=> $stable(cnt));
endmodule

// File: rtl/ackt_evt_reg.sv
module ackt_evt_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       fire,
  input  logic [2:0] code,
  input  logic       bad_type,
  output logic       evt_valid,
  output logic [2:0] evt_code,
  output logic       err_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      evt_valid <= 1'b0;
      evt_code  <= 3'd0;
      err_flag  <= 1'b0;
    end else begin
      evt_valid <= fire;
      evt_code  <= fire ? code : 3'd0;
      if (bad_type) err_flag <= 1'b1;
    end
  end

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);

  p_bad_no_event_r9: assert property (@(posedge clk) disable iff (rst)
    bad_type |=> (!evt_valid && err_flag));
endmodule

// File: rtl/ackt_tracker.sv
module ackt_tracker
  import ackt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int ACK_W = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    alloc,
  input  logic                    rsp_valid,
  input  logic [2:0]              rsp_type,
  input  logic                    rsp_from_peer,
  input  logic signed [ACK_W-1:0] rsp_ack_cnt,
  input  logic [2:0]              txn_state,
  output logic                    evt_valid,
  output logic [2:0]              evt_code,
  output logic signed [CNT_W-1:0] pending_cnt,
  output logic                    err_flag
);
  logic                    take;
  logic                    cls_fire;
  logic [2:0]              cls_code;
  logic                    cls_upd;
  logic signed [CNT_W-1:0] cls_cnt;
  logic                    cls_bad;

  // allocation wins over a response in the same cycle
  assign take = rsp_valid && !alloc;

  ackt_classify #(.CNT_W(CNT_W), .ACK_W(ACK_W)) u_cls (
    .in_valid (take),
    .in_type  (rsp_type),
    .in_peer  (rsp_from_peer),
    .in_ack   (rsp_ack_cnt),
    .in_state (txn_state),
    .cur_cnt  (pending_cnt),
    .fire     (cls_fire),
    .code     (cls_code),
    .upd_en   (cls_upd),
    .upd_cnt  (cls_cnt),
    .bad_type (cls_bad)
  );

  ackt_count_reg #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (alloc),
    .upd_en  (cls_upd),
    .upd_cnt (cls_cnt),
    .cnt     (pending_cnt)
  );

  ackt_evt_reg u_evt (
    .clk       (clk),
    .rst       (rst),
    .fire      (cls_fire),
    .code      (cls_code),
    .bad_type  (cls_bad),
    .evt_valid (evt_valid),
    .evt_code  (evt_code),
    .err_flag  (err_flag)
  );

  p_xdata_event_r3: assert property (@(posedge clk) disable iff (rst)
    (take && rsp_type == RSP_XDATA) |=> (evt_valid && evt_code == EV_XDATA));

  p_final_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && (evt_code == EV_DATA_LAST || evt_code == EV_ACK_LAST))
      |-> (pending_cnt == '0));

  p_alloc_drops_r2: assert property (@(posedge clk) disable iff (rst)
    alloc |=> !evt_valid);

  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |=> !evt_valid);
endmodule

// File: tb/tb_ackt_tracker.sv
module tb_ackt_tracker;
  localparam int CNT_W = 8;
  localparam int ACK_W = 6;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    alloc = 1'b0;
  logic                    rsp_valid = 1'b0;
  logic [2:0]              rsp_type = 3'd0;
  logic                    rsp_from_peer = 1'b0;
  logic signed [ACK_W-1:0] rsp_ack_cnt = '0;
  logic [2:0]              txn_state = 3'd0;
  logic                    evt_valid;
  logic [2:0]              evt_code;
  logic signed [CNT_W-1:0] pending_cnt;
  logic                    err_flag;

  int checks = 0;
  int errors = 0;
  int model  = 0;

  always #10 clk = ~clk;

  ackt_tracker #(.CNT_W(CNT_W), .ACK_W(ACK_W)) dut (
    .clk(clk), .rst(rst), .alloc(alloc), .rsp_valid(rsp_valid),
    .rsp_type(rsp_type), .rsp_from_peer(rsp_from_peer),
    .rsp_ack_cnt(rsp_ack_cnt), .txn_state(txn_state),
    .evt_valid(evt_valid), .evt_code(evt_code),
    .pending_cnt(pending_cnt), .err_flag(err_flag)
  );

  task automatic expect_out(string req, bit ev_v, logic [2:0] ev, int cnt, bit err);
    checks++;
    if (evt_valid !== ev_v || (ev_v && evt_code !== ev) ||
        int'(pending_cnt) != cnt || err_flag !== err) begin
      errors++;
      $display("FAIL %s: got v=%0b ev=%0d cnt=%0d err=%0b, expected v=%0b ev=%0d cnt=%0d err=%0b",
               req, evt_valid, evt_code, int'(pending_cnt), err_flag, ev_v, ev, cnt, err);
    end
  endtask

  // drives one cycle at a falling edge, returns at the next falling edge
  task automatic cycle(bit al, bit v, logic [2:0] t, bit peer, int ack, logic [2:0] st);
    alloc = al; rsp_valid = v; rsp_type = t; rsp_from_peer = peer;
    rsp_ack_cnt = ACK_W'(ack); txn_state = st;
    @(posedge clk);
    @(negedge clk);
    alloc = 1'b0; rsp_valid = 1'b0; rsp_type = 3'd0; rsp_from_peer = 1'b0;
    rsp_ack_cnt = '0; txn_state = 3'd0;
  endtask

  task automatic do_alloc();
    cycle(1, 0, 0, 0, 0, 0);
    model = 0;
  endtask

  task automatic t_reset();
    expect_out("R1", 0, 0, 0, 0);
  endtask

  task automatic t_alloc();
    cycle(0, 1, 3'd2, 0, 1, 3'd3);
    model = -1;
    expect_out("R6", 1, 3'd6, model, 0);
    do_alloc();
    expect_out("R2", 0, 0, 0, 0);
    cycle(0, 1, 3'd2, 0, 1, 3'd3);
    // response in the same cycle as alloc is dropped
    cycle(1, 1, 3'd2, 0, 1, 3'd3);
    model = 0;
    expect_out("R2", 0, 0, 0, 0);
  endtask

  task automatic t_acks_first();
    do_alloc();
    cycle(0, 1, 3'd2, 0, 1, 3'd3);
    expect_out("R6", 1, 3'd6, -1, 0);
    cycle(0, 1, 3'd2, 0, 1, 3'd3);
    expect_out("R7", 1, 3'd6, -2, 0);
    cycle(0, 1, 3'd0, 0, -2, 3'd3);
    expect_out("R5", 1, 3'd3, 0, 0);
  endtask

  task automatic t_data_first();
    do_alloc();
    cycle(0, 1, 3'd0, 0, -2, 3'd4);
    expect_out("R5", 1, 3'd4, 2, 0);
    cycle(0, 1, 3'd2, 0, 1, 3'd4);
    expect_out("R6", 1, 3'd6, 1, 0);
    cycle(0, 1, 3'd2, 0, 1, 3'd4);
    expect_out("R6", 1, 3'd5, 0, 0);
    cycle(0, 1, 3'd0, 0, 0, 3'd3);
    expect_out("R5", 1, 3'd3, 0, 0);
  endtask

  task automatic t_exclusive();
    do_alloc();
    cycle(0, 1, 3'd0, 0, -1, 3'd3);
    expect_out("R5", 1, 3'd4, 1, 0);
    cycle(0, 1, 3'd1, 0, 5, 3'd1);
    expect_out("R3", 1, 3'd1, 1, 0);
  endtask

  task automatic t_peer();
    do_alloc();
    cycle(0, 1, 3'd0, 1, 0, 3'd1);
    expect_out("R4", 1, 3'd2, 0, 0);
    cycle(0, 1, 3'd0, 1, 3, 3'd2);
    expect_out("R4", 1, 3'd2, 0, 0);
    cycle(0, 1, 3'd0, 1, 0, 3'd3);
    expect_out("R4", 1, 3'd3, 0, 0);
  endtask

  task automatic t_wb_idle();
    do_alloc();
    cycle(0, 1, 3'd2, 0, 1, 3'd5);
    cycle(0, 1, 3'd3, 0, 4, 3'd5);
    expect_out("R8", 1, 3'd7, -1, 0);
    cycle(0, 0, 3'd2, 0, 1, 3'd5);
    expect_out("R10", 0, 0, -1, 0);
  endtask

  task automatic t_bad();
    do_alloc();
    cycle(0, 1, 3'd5, 0, 1, 3'd3);
    expect_out("R9", 0, 0, 0, 1);
    cycle(0, 1, 3'd2, 0, 1, 3'd3);
    expect_out("R9", 1, 3'd6, -1, 1);
    do_alloc();
    expect_out("R9", 0, 0, 0, 1);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    expect_out("R1", 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_alloc();
    t_acks_first();
    t_data_first();
    t_exclusive();
    t_peer();
    t_wb_idle();
    t_bad();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule